// File: doc/BRIEF.md
# Multicore Coherency Controller Register Bank

This block is the register bank of a coherency controller shared by up to four processor cores. It sits behind a simple bus slave port that carries a byte address, 32-bit write data, an access size of 1, 2 or 4 bytes, and separate read and write strobes. The window covers 256 bytes. It holds a one-bit enable control and a 32-bit per-core power status word that can be updated one byte lane at a time. It also presents a read-only configuration word derived from the core count parameter.

Every other offset in the window is a placeholder. These include the invalidate-all, filter start and end, and access-control slots. Each of them reads as zero and drops writes. Reset clears only the enable bit. The power status word survives reset, so software can keep per-core power state across a controller reset.

Read data is registered. It appears one clock after the read strobe and holds until the next read.

Top module: `coh_cfg_regbank`

## Requirements
- R1: A write to offset 0x00 stores only bit 0 of the write data as the enable bit. A read of 0x00 returns that bit in bit 0 with bits 31:1 zero.
- R2: A read of offset 0x04 returns ((2^N − 1) << 4) | (N − 1), where N is the core count parameter (default 1, giving 0x10; N = 3 gives 0x72). Writes to 0x04 change nothing.
- R3: A write at offset 0x08 + k (k = 0..3) with size S takes the S-byte mask (0xFF, 0xFFFF or 0xFFFFFFFF) and the write data ANDed with it, and shifts both left by 8k. Bits shifted past bit 31 are dropped. The masked status bits are then replaced by the shifted data, and all other bits keep their value.
- R4: A read at offset 0x08 + k returns the status word shifted right by 8k, zero-filled from the top.
- R5: Offset 0x0C, offsets 0x40, 0x44, 0x50 and 0x54, and every other offset not named in R1 to R4 read as zero. Writes to them leave the enable bit and the status word unchanged.
- R6: Reset, which is synchronous and active high, clears the enable bit and leaves the power status word unchanged.
- R7: A write whose size field is anything other than 1, 2 or 4 changes no state.
- R8: Read data is updated on the clock edge where the read strobe is high, and holds its value while the read strobe is low. A read issued in the same cycle as a write returns the state from before that write.
- R9: The power status word is zero at power-up, before any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4 valid) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench sweeps every byte offset of the status word against every value of the size field. It checks the truncation at the upper lanes: a 4-byte write at 0x0A or 0x0B that wrapped or leaked would corrupt the low half, and a design that ignored the size mask would clobber neighbouring lanes. It writes all ones to every unmapped offset, including the unaligned neighbours of the control and configuration registers. It then confirms that enable and status are unchanged, which catches a decode that matches on word address alone. It also covers a reset with a status value held, which exposes a status register that a designer wired to reset, and a read and write in the same cycle, which shows whether the read port forwards write data.

// File: rtl/coh_regbank_pkg.sv
package coh_regbank_pkg;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_PWR  = 2'd3
  } rd_sel_e;

  localparam logic [7:0] OFF_CTRL     = 8'h00;
  localparam logic [7:0] OFF_CFG      = 8'h04;
  localparam logic [5:0] OFF_PWR_WORD = 6'h02;  // 0x08..0x0B

  function automatic logic size_is_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

endpackage

// File: rtl/coh_bus_decode.sv
module coh_bus_decode
  import coh_regbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic              wr,
  output logic              ctrl_we,
  output logic              pwr_we,
  output logic [LANE_W-1:0] lane,
  output logic [DATA_W-1:0] size_mask,
  output rd_sel_e           rd_sel
);

  logic legal;
  logic hit_ctrl, hit_cfg, hit_pwr;

  always_comb begin
    legal    = size_is_legal(size);
    hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
    hit_cfg  = (addr == ADDR_W'(OFF_CFG));
    hit_pwr  = (addr[ADDR_W-1:LANE_W] == (ADDR_W-LANE_W)'(OFF_PWR_WORD));
    lane     = addr[LANE_W-1:0];
  end

  always_comb begin
    case (size)
      3'd1:    size_mask = DATA_W'(8'hFF);
      3'd2:    size_mask = DATA_W'(16'hFFFF);
      3'd4:    size_mask = '1;
      default: size_mask = '0;
    endcase
  end

  always_comb begin
    ctrl_we = wr && legal && hit_ctrl;
    pwr_we  = wr && legal && hit_pwr;
  end

  always_comb begin
    if (hit_ctrl)      rd_sel = SEL_CTRL;
    else if (hit_cfg)  rd_sel = SEL_CFG;
    else if (hit_pwr)  rd_sel = SEL_PWR;
    else               rd_sel = SEL_ZERO;
  end

endmodule

// File: rtl/coh_pwr_status.sv
module coh_pwr_status #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] size_mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status
);

  logic [DATA_W-1:0] status_q = '0;
  logic [DATA_W-1:0] mask_sh;
  logic [DATA_W-1:0] data_sh;

  // Shift in the native width so bits beyond the top lane fall away.
  always_comb begin
    mask_sh = size_mask << {lane, 3'b000};
    data_sh = (wdata & size_mask) << {lane, 3'b000};
  end

  // No reset: the word is retained across controller reset.
  always_ff @(posedge clk) begin
    if (we) status_q <= (status_q & ~mask_sh) | data_sh;
  end

  assign status = status_q;

endmodule

// File: rtl/coh_read_port.sv
module coh_read_port
  import coh_regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  rd_sel_e           sel,
  input  logic [LANE_W-1:0] lane,
  input  logic              ctrl,
  input  logic [DATA_W-1:0] cfg,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    case (sel)
      SEL_CTRL: rdata_d = DATA_W'(ctrl);
      SEL_CFG:  rdata_d = cfg;
      SEL_PWR:  rdata_d = status >> {lane, 3'b000};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata_q)); // R8

endmodule

// File: rtl/coh_cfg_regbank.sv
module coh_cfg_regbank
  import coh_regbank_pkg::*;
#(
  parameter int N_CORES = 1,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam logic [DATA_W-1:0] CFG_WORD =
    DATA_W'(((1 << N_CORES) - 1) << 4) | DATA_W'(N_CORES - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [2:0]        bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata
);

  generate
    if (N_CORES < 1 || N_CORES > 4) begin : g_bad_cores
      $error("coh_cfg_regbank: N_CORES must lie in 1..4");
    end
  endgenerate

  logic              ctrl_we, pwr_we;
  logic [LANE_W-1:0] lane;
  logic [DATA_W-1:0] size_mask;
  rd_sel_e           rd_sel;
  logic              ctrl_q;
  logic [DATA_W-1:0] pwr_status;

  coh_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr      (bus_addr),
    .size      (bus_size),
    .wr        (bus_wr),
    .ctrl_we   (ctrl_we),
    .pwr_we    (pwr_we),
    .lane      (lane),
    .size_mask (size_mask),
    .rd_sel    (rd_sel)
  );

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= 1'b0;
    else if (ctrl_we) ctrl_q <= bus_wdata[0];
  end

  coh_pwr_status #(.DATA_W(DATA_W)) u_pwr (
    .clk       (clk),
    .we        (pwr_we),
    .lane      (lane),
    .size_mask (size_mask),
    .wdata     (bus_wdata),
    .status    (pwr_status)
  );

  coh_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (bus_rd),
    .sel    (rd_sel),
    .lane   (lane),
    .ctrl   (ctrl_q),
    .cfg    (CFG_WORD),
    .status (pwr_status),
    .rdata  (bus_rdata)
  );

  AST_CTRL_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFF_CTRL)) |=> (bus_rdata[DATA_W-1:1] == '0)); // R1
  AST_CFG_WORD: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFF_CFG)) |=> (bus_rdata == CFG_WORD)); // R2
  AST_PWR_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(pwr_status)); // R3
  AST_INVAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(8'h0C)) |=> (bus_rdata == '0)); // R5
  AST_BAD_SIZE_NO_PWR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !size_is_legal(bus_size)) |=> $stable(pwr_status)); // R7
  AST_BAD_SIZE_NO_CTRL: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !size_is_legal(bus_size)) |=> $stable(ctrl_q)); // R7

endmodule

// File: tb/coh_cfg_regbank_tb_top.sv
`timescale 1ns/100ps
module coh_cfg_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [2:0]  bus_size = 3'd4;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata, def_rdata;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_status = '0;
  logic        m_ctrl = 1'b0;

  always #2.5 clk = ~clk;

  coh_cfg_regbank #(.N_CORES(3)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  coh_cfg_regbank dut_def_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(def_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic bit legal(input logic [2:0] sz);
    return sz == 3'd1 || sz == 3'd2 || sz == 3'd4;
  endfunction

  function automatic logic [31:0] smask(input logic [2:0] sz);
    case (sz)
      3'd1: return 32'h0000_00FF;
      3'd2: return 32'h0000_FFFF;
      3'd4: return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  // Writes on one edge; the bench model follows the requirements.
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [2:0] sz);
    logic [63:0] m, v;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (legal(sz)) begin
      if (a == 8'h00) m_ctrl = d[0];
      if (a >= 8'h08 && a <= 8'h0B) begin
        m = {32'h0, smask(sz)} << (8 * (a - 8'h08));
        v = {32'h0, d & smask(sz)} << (8 * (a - 8'h08));
        m_status = (m_status & ~m[31:0]) | v[31:0];
      end
    end
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] r);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    r = bus_rdata;
  endtask

  initial begin
    logic [31:0] r, held;
    logic [31:0] pats [3];
    pats[0] = 32'hA5C3_1E79; pats[1] = 32'h5A3C_E186; pats[2] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    // R6: reset state of the read port and the enable bit
    check("R6 reset rdata", bus_rdata, 32'h0);
    rst = 1'b0;

    // R9: status reads zero at power-up
    bus_read(8'h08, r); check("R9 status power-up", r, 32'h0);
    bus_read(8'h00, r); check("R6 ctrl after reset", r, 32'h0);

    // R2: configuration word for N=3 and default N=1, write ignored
    bus_read(8'h04, r);
    check("R2 cfg N=3", r, 32'h72);
    check("R2 cfg default N=1", def_rdata, 32'h10);
    bus_write(8'h04, 32'hFFFF_FFFF, 3'd4);
    bus_read(8'h04, r); check("R2 cfg after write", r, 32'h72);

    // R1: only bit 0 kept
    bus_write(8'h00, 32'hFFFF_FFFE, 3'd4);
    bus_read(8'h00, r); check("R1 ctrl even value", r, 32'h0);
    bus_write(8'h00, 32'hFFFF_FFFF, 3'd1);
    bus_read(8'h00, r); check("R1 ctrl odd value", r, 32'h1);

    // R3 R4 R7: sweep lanes, sizes and patterns
    for (int p = 0; p < 3; p++) begin
      for (int ln = 0; ln < 4; ln++) begin
        for (int sz = 0; sz < 8; sz++) begin
          bus_write(8'h08 + 8'(ln), pats[p] ^ {8'(sz), 8'(ln), 16'h0}, 3'(sz));
          for (int k = 0; k < 4; k++) begin
            bus_read(8'h08 + 8'(k), r);
            if (legal(3'(sz))) check("R3 R4 status lane merge", r, m_status >> (8 * k));
            else               check("R7 illegal size dropped", r, m_status >> (8 * k));
          end
        end
      end
    end

    // R3: explicit truncation at the top lanes
    bus_write(8'h08, 32'h1111_1111, 3'd4);
    bus_write(8'h0A, 32'hABCD_EF01, 3'd4);
    bus_read(8'h08, r); check("R3 4-byte at 0x0A truncates", r, 32'hEF01_1111);
    bus_write(8'h0B, 32'h1234_5677, 3'd2);
    bus_read(8'h08, r); check("R3 2-byte at 0x0B truncates", r, 32'h7701_1111);

    // R7: illegal size on the enable bit
    bus_write(8'h00, 32'h0, 3'd3);
    bus_read(8'h00, r); check("R7 ctrl illegal size", r, {31'h0, m_ctrl});

    // R5: every other offset reads zero and ignores writes
    for (int a = 0; a < 256; a++) begin
      if (a == 8'h00 || a == 8'h04 || (a >= 8'h08 && a <= 8'h0B)) continue;
      bus_write(8'(a), 32'hFFFF_FFFF, 3'd4);
      bus_write(8'(a), 32'h0000_0000, 3'd1);
      bus_read(8'(a), r);
      if (r !== 32'h0) check("R5 unmapped reads zero", r, 32'h0);
      else n_checks++;
    end
    bus_read(8'h08, r); check("R5 status untouched by unmapped writes", r, m_status);
    bus_read(8'h00, r); check("R5 ctrl untouched by unmapped writes", r, {31'h0, m_ctrl});

    // R8: read data holds with no read strobe
    bus_read(8'h04, held);
    repeat (4) @(negedge clk);
    check("R8 rdata hold", bus_rdata, held);

    // R8: read and write in the same cycle returns the old value
    @(negedge clk);
    bus_addr = 8'h08; bus_wdata = 32'h0BAD_F00D; bus_size = 3'd4;
    bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R8 read before write", bus_rdata, m_status);
    m_status = 32'h0BAD_F00D;
    bus_read(8'h08, r); check("R8 write then landed", r, 32'h0BAD_F00D);

    // R6: reset clears enable, keeps status
    bus_write(8'h00, 32'h1, 3'd4);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    m_ctrl = 1'b0;
    bus_read(8'h00, r); check("R6 ctrl cleared", r, 32'h0);
    bus_read(8'h08, r); check("R6 status kept", r, 32'h0BAD_F00D);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5 * 190000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule